// File: doc/BRIEF.md
# Three-Phase Gate-Drive Interlock Controller

This block sits between a PWM generator and the gate drivers of a three-phase bridge. Each phase (U, V, W) has a high-side and a low-side request, and the block turns those six active-high requests into six gate enables. Within a phase the two enables are never on together. A request for both switches at once turns both off. No switch turns on until the phase has spent a programmable dead time with both switches off.

On top of the per-phase logic there are four protection paths. The first is a global active-low shutdown line. The second is an undervoltage lockout on the control supply, with hysteresis. The third is a lockout with hysteresis on each phase's high-side supply, which blocks only that phase's high switch. The fourth is an overcurrent trip. The trip turns phase U off directly and pulls the shared open-drain shutdown line low. Phases V and W stop only when that line is seen low. The open-drain pull-down is held while the trip is present and for a programmable number of cycles after it clears. All asynchronous inputs pass through two-flop synchronisers. Supply readings are unsigned millivolt codes that are synchronous to the clock.

Top module: `tri_gate_guard`

## Requirements
- R1: During reset and after it, all gate enables and the fault drive are low. A dead-time counter is preloaded, so a steady lone request right at reset release turns its gate on at the (DEAD_CYC+1)-th rising edge and not earlier.
- R2: A low level on the shutdown input (sdInN = 0) turns off all six gate enables on the third rising edge after it appears, whatever the requests are.
- R3: When both requests of a phase are high, both gate enables of that phase are off three edges later.
- R4: When both requests of a phase are low, both enables are off. A lone low-side request drives only gateLo of that phase, and a lone high-side request drives only gateHi (bit 0 = U, bit 1 = V, bit 2 = W).
- R5: The two enables of a phase are never high together. A gate turns on only at an edge before which both gates of its phase were off for at least DEAD_CYC consecutive edges. On a high-to-low handover, both are seen off for exactly DEAD_CYC+1 cycles.
- R6: Three rising edges after tripIn rises, both phase U enables are off and faultOe is high.
- R7: A trip does not act on phases V and W directly. They turn off only once the shutdown input is seen low, for example through the fault drive looping back on the shared line.
- R8: After tripIn falls, faultOe stays high for HOLD_CYC+2 sampled cycles and then releases.
- R9: Control-supply lockout is engaged from reset. It releases at a reading of at least 12000 mV and engages below 10500 mV. Readings in between keep the current state. While it is engaged, all enables are off.
- R10: Each phase's high-side lockout releases at 11500 mV or more and engages below 10000 mV, with the state held in between. It blocks only that phase's gateHi. gateLo and the other phases are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hiReq | input | 3 | High-side PWM requests, bit 0 = U |
| loReq | input | 3 | Low-side PWM requests, bit 0 = U |
| tripIn | input | 1 | Overcurrent trip flag, active high |
| sdInN | input | 1 | Level of the shared shutdown line, active low |
| vccMv | input | 16 | Control-supply reading in mV |
| vbsMv | input | 48 | High-side supply readings in mV, phase p in bits [16p+15:16p] |
| gateHi | output | 3 | High-side gate enables |
| gateLo | output | 3 | Low-side gate enables |
| faultOe | output | 1 | Pull-down enable of the open-drain shutdown line |

## Verification
The per-cycle properties check the following:
- the two switches of a phase are never both on;
- the dead-time gap before any turn-on;
- the forced-off results of shutdown, interlock, control-supply lockout and high-side lockout, each at its fixed pipeline depth;
- phase U turning off under a trip;
- the fault drive releasing only after the hold time.

Only the bench scenarios can show the remaining behaviour:
- the exact turn-on cycle after reset;
- the length of a handover;
- hysteresis, where a reading in the band keeps the previous state;
- V and W surviving a trip when the shared line is not looped back;
- the exact number of hold cycles.

A reference model in the bench follows every output through randomised request, supply, shutdown and trip traffic.

// File: rtl/tri_gate_pkg.sv
package tri_gate_pkg;
  localparam int NPH  = 3;
  localparam int MV_W = 16;

  // control -> datapath strobes, one bit per phase
  typedef struct packed {
    logic [NPH-1:0] reqHi;
    logic [NPH-1:0] reqLo;
    logic [NPH-1:0] permHi;
    logic [NPH-1:0] permLo;
  } gateStrobe_t;
endpackage

// File: rtl/tgg_sync.sv
module tgg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] qOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      qOut   <= '0;
    end else begin
      stage1 <= dIn;
      qOut   <= stage1;
    end
  end
endmodule

// File: rtl/tgg_control.sv
module tgg_control
  import tri_gate_pkg::*;
#(
  parameter int VCC_ON_MV  = 12000,
  parameter int VCC_OFF_MV = 10500,
  parameter int VBS_ON_MV  = 11500,
  parameter int VBS_OFF_MV = 10000,
  parameter int HOLD_CYC   = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPH-1:0]    hiReq,
  input  logic [NPH-1:0]    loReq,
  input  logic              tripIn,
  input  logic              sdInN,
  input  logic [MV_W-1:0]   vccMv,
  input  logic [NPH*MV_W-1:0] vbsMv,
  output gateStrobe_t       strobe,
  output logic              faultOe
);
  localparam int SYNC_W = 2 * NPH + 2;
  localparam int HOLD_W = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [NPH-1:0] TRIP_MASK = NPH'(1);  // trip cuts phase U only

  logic [SYNC_W-1:0] rawIn, syncOut;
  logic [NPH-1:0]    hiSync, loSync, vbsOk;
  logic              tripSync, sdSync, vccOk;
  logic [HOLD_W-1:0] holdCnt;

  assign rawIn = {sdInN, tripIn, loReq, hiReq};

  tgg_sync #(.W(SYNC_W)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (rawIn),
    .qOut (syncOut)
  );

  assign hiSync   = syncOut[NPH-1:0];
  assign loSync   = syncOut[2*NPH-1:NPH];
  assign tripSync = syncOut[2*NPH];
  assign sdSync   = syncOut[2*NPH+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                vccOk <= 1'b0;
    else if (vccMv >= MV_W'(VCC_ON_MV))       vccOk <= 1'b1;
    else if (vccMv <  MV_W'(VCC_OFF_MV))      vccOk <= 1'b0;
  end

  for (genvar p = 0; p < NPH; p++) begin : g_vbs
    logic [MV_W-1:0] level;
    assign level = vbsMv[p*MV_W +: MV_W];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              vbsOk[p] <= 1'b0;
      else if (level >= MV_W'(VBS_ON_MV))     vbsOk[p] <= 1'b1;
      else if (level <  MV_W'(VBS_OFF_MV))    vbsOk[p] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      faultOe <= 1'b0;
    end else begin
      faultOe <= tripSync || (holdCnt != '0);
      if (tripSync)            holdCnt <= HOLD_W'(HOLD_CYC);
      else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
    end
  end

  logic [NPH-1:0] enable;
  assign enable = {NPH{sdSync & vccOk}} & ~(TRIP_MASK & {NPH{tripSync}});

  always_comb begin
    strobe.reqHi  = hiSync;
    strobe.reqLo  = loSync;
    strobe.permLo = enable;
    strobe.permHi = enable & vbsOk;
  end
endmodule

// File: rtl/tgg_datapath.sv
module tgg_datapath
  import tri_gate_pkg::*;
#(
  parameter int DEAD_CYC = 18
) (
  input  logic           clk,
  input  logic           rstN,
  input  gateStrobe_t    strobe,
  output logic [NPH-1:0] gateHi,
  output logic [NPH-1:0] gateLo
);
  localparam int DW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic [DW-1:0] deadCnt;
    logic          wantHi, wantLo, gapDone;

    assign wantHi  = strobe.reqHi[p] & ~strobe.reqLo[p] & strobe.permHi[p];
    assign wantLo  = strobe.reqLo[p] & ~strobe.reqHi[p] & strobe.permLo[p];
    assign gapDone = (deadCnt == '0) & ~gateHi[p] & ~gateLo[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        deadCnt   <= DW'(DEAD_CYC);
        gateHi[p] <= 1'b0;
        gateLo[p] <= 1'b0;
      end else begin
        if (gateHi[p] || gateLo[p]) deadCnt <= DW'(DEAD_CYC);
        else if (deadCnt != '0)     deadCnt <= deadCnt - 1'b1;
        gateHi[p] <= wantHi & (gateHi[p] | gapDone);
        gateLo[p] <= wantLo & (gateLo[p] | gapDone);
      end
    end
  end
endmodule

// File: rtl/tri_gate_guard.sv
module tri_gate_guard
  import tri_gate_pkg::*;
#(
  parameter int DEAD_CYC   = 18,
  parameter int HOLD_CYC   = 50,
  parameter int VCC_ON_MV  = 12000,
  parameter int VCC_OFF_MV = 10500,
  parameter int VBS_ON_MV  = 11500,
  parameter int VBS_OFF_MV = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        hiReq,
  input  logic [2:0]        loReq,
  input  logic              tripIn,
  input  logic              sdInN,
  input  logic [15:0]       vccMv,
  input  logic [47:0]       vbsMv,
  output logic [2:0]        gateHi,
  output logic [2:0]        gateLo,
  output logic              faultOe
);
  gateStrobe_t strobe;

  tgg_control #(
    .VCC_ON_MV (VCC_ON_MV),  .VCC_OFF_MV(VCC_OFF_MV),
    .VBS_ON_MV (VBS_ON_MV),  .VBS_OFF_MV(VBS_OFF_MV),
    .HOLD_CYC  (HOLD_CYC)
  ) u_control (
    .clk(clk), .rstN(rstN), .hiReq(hiReq), .loReq(loReq),
    .tripIn(tripIn), .sdInN(sdInN), .vccMv(vccMv), .vbsMv(vbsMv),
    .strobe(strobe), .faultOe(faultOe)
  );

  tgg_datapath #(.DEAD_CYC(DEAD_CYC)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .gateHi(gateHi), .gateLo(gateLo)
  );
endmodule

// File: rtl/tri_gate_guard_chk.sv
module tri_gate_guard_chk #(
  parameter int DEAD_CYC   = 18,
  parameter int HOLD_CYC   = 50,
  parameter int VCC_OFF_MV = 10500,
  parameter int VBS_OFF_MV = 10000
) (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  hiReq,
  input logic [2:0]  loReq,
  input logic        tripIn,
  input logic        sdInN,
  input logic [15:0] vccMv,
  input logic [47:0] vbsMv,
  input logic [2:0]  gateHi,
  input logic [2:0]  gateLo,
  input logic        faultOe
);
  logic [2:0]  sinceRst;
  logic [15:0] tripLowRun;
  logic        warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst   <= '0;
      tripLowRun <= '0;
    end else begin
      if (sinceRst != 3'd7) sinceRst <= sinceRst + 1'b1;
      if (tripIn)                   tripLowRun <= '0;
      else if (tripLowRun != '1)    tripLowRun <= tripLowRun + 1'b1;
    end
  end
  assign warm = (sinceRst >= 3'd4);

  // R2: shutdown forces every gate off
  a_r2_shutdown_off: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !$past(sdInN, 3)) |-> (gateHi == 3'b000 && gateLo == 3'b000));

  // R6: trip cuts phase U and drives the fault line
  a_r6_trip_cuts_u: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(tripIn, 3)) |-> (!gateHi[0] && !gateLo[0] && faultOe));

  // R9: control-supply lockout
  a_r9_vcc_lockout: assert property (@(posedge clk) disable iff (!rstN)
    (warm && ($past(vccMv, 2) < 16'(VCC_OFF_MV))) |-> (gateHi == 3'b000 && gateLo == 3'b000));

  // R8: release of the fault drive only after the hold time
  a_r8_fault_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultOe) |-> (tripLowRun >= 16'(HOLD_CYC)));

  for (genvar p = 0; p < 3; p++) begin : g_ph
    logic [15:0] offRun;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         offRun <= '0;
      else if (gateHi[p] || gateLo[p])   offRun <= '0;
      else if (offRun != '1)             offRun <= offRun + 1'b1;
    end

    // R5: never both on
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
      !(gateHi[p] && gateLo[p]));

    // R5: dead gap before any turn-on
    a_r5_dead_gap_hi: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateHi[p]) |-> (offRun >= 16'(DEAD_CYC)));
    a_r5_dead_gap_lo: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateLo[p]) |-> (offRun >= 16'(DEAD_CYC)));

    // R3: both requests high gives both off
    a_r3_interlock: assert property (@(posedge clk) disable iff (!rstN)
      (warm && $past(hiReq[p] && loReq[p], 3)) |-> (!gateHi[p] && !gateLo[p]));

    // R10: high-side lockout blocks gateHi of that phase
    a_r10_vbs_lockout: assert property (@(posedge clk) disable iff (!rstN)
      (warm && ($past(vbsMv[p*16 +: 16], 2) < 16'(VBS_OFF_MV))) |-> !gateHi[p]);
  end
endmodule

bind tri_gate_guard tri_gate_guard_chk #(
  .DEAD_CYC(DEAD_CYC), .HOLD_CYC(HOLD_CYC),
  .VCC_OFF_MV(VCC_OFF_MV), .VBS_OFF_MV(VBS_OFF_MV)
) u_chk (
  .clk(clk), .rstN(rstN), .hiReq(hiReq), .loReq(loReq), .tripIn(tripIn),
  .sdInN(sdInN), .vccMv(vccMv), .vbsMv(vbsMv), .gateHi(gateHi),
  .gateLo(gateLo), .faultOe(faultOe)
);

// File: tb/tri_gate_guard_bench.sv
`timescale 1ns/1ps
module tri_gate_guard_bench;
  localparam int DEAD = 18;
  localparam int HOLD = 50;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  hiReq, loReq;
  logic        tripIn, sdExt, fbEn;
  logic [15:0] vccMv;
  logic [47:0] vbsMv;
  logic [2:0]  gateHi, gateLo;
  logic        faultOe;
  wire         sdInN = sdExt & ~(fbEn & faultOe);  // wired-AND open-drain line

  int  nChecks = 0, nFails = 0;
  bit  modelOn = 0, finished = 0;

  always #2.5 clk = ~clk;

  tri_gate_guard #(.DEAD_CYC(DEAD), .HOLD_CYC(HOLD)) u_tri_gate_guard (
    .clk(clk), .rstN(rstN), .hiReq(hiReq), .loReq(loReq), .tripIn(tripIn),
    .sdInN(sdInN), .vccMv(vccMv), .vbsMv(vbsMv), .gateHi(gateHi),
    .gateLo(gateLo), .faultOe(faultOe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit hyst(input bit cur, input int lvl, input int onMv, input int offMv);
    if (lvl >= onMv) return 1'b1;
    if (lvl < offMv) return 1'b0;
    return cur;
  endfunction

  // Reference model built from the requirements
  logic [2:0] mH1, mH2, mL1, mL2, mGH, mGL, mVbs;
  logic       mT1, mT2, mS1, mS2, mVcc, mFo;
  int         mTLow;
  int         mRun [3];

  always @(posedge clk) begin
    if (!rstN) begin
      mH1 <= 0; mH2 <= 0; mL1 <= 0; mL2 <= 0; mT1 <= 0; mT2 <= 0;
      mS1 <= 0; mS2 <= 0; mVcc <= 0; mVbs <= 0; mFo <= 0; mTLow <= 1 << 20;
      mGH <= 0; mGL <= 0;
      for (int p = 0; p < 3; p++) mRun[p] <= 0;
    end else begin
      mH1 <= hiReq; mH2 <= mH1; mL1 <= loReq; mL2 <= mL1;
      mT1 <= tripIn; mT2 <= mT1; mS1 <= sdInN; mS2 <= mS1;
      mVcc <= hyst(mVcc, int'(vccMv), 12000, 10500);
      mFo <= mT2 || (mTLow < HOLD);
      mTLow <= mT2 ? 0 : mTLow + 1;
      for (int p = 0; p < 3; p++) begin
        bit en, wH, wL, off, rdy;
        mVbs[p] <= hyst(mVbs[p], int'(vbsMv[p*16 +: 16]), 11500, 10000);
        en  = mS2 && mVcc && !(p == 0 && mT2);
        wH  = en && mVbs[p] && mH2[p] && !mL2[p];
        wL  = en && mL2[p] && !mH2[p];
        off = !mGH[p] && !mGL[p];
        rdy = off && (mRun[p] >= DEAD);
        mGH[p] <= wH && (mGH[p] || rdy);
        mGL[p] <= wL && (mGL[p] || rdy);
        mRun[p] <= off ? ((mRun[p] < 1000) ? mRun[p] + 1 : mRun[p]) : 0;
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      chk(gateHi == mGH, "R4 model gateHi", gateHi, mGH);
      chk(gateLo == mGL, "R5 model gateLo", gateLo, mGL);
      chk(faultOe == mFo, "R8 model faultOe", faultOe, mFo);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    int cnt;
    void'($urandom(32'd1234));
    rstN = 0; hiReq = 0; loReq = 0; tripIn = 0; sdExt = 1; fbEn = 1;
    vccMv = 16'd15000; vbsMv = {3{16'd15000}};
    step(3);
    chk(gateHi == 0 && gateLo == 0, "R1 reset gates", {gateHi, gateLo}, 0);
    chk(faultOe == 0, "R1 reset fault", faultOe, 0);
    rstN = 1; hiReq = 3'b001; modelOn = 1;
    step(DEAD);
    chk(gateHi[0] == 0, "R1 no turn-on before dead time", gateHi[0], 0);
    step(1);
    chk(gateHi[0] == 1, "R4 lone high request", gateHi[0], 1);

    // R5 handover timing
    hiReq = 0; loReq = 3'b001; cnt = 0;
    for (int i = 0; i < 80; i++) begin
      step(1);
      if (!gateHi[0] && !gateLo[0]) cnt++;
      if (gateLo[0]) break;
    end
    chk(cnt == DEAD + 1, "R5 handover gap", cnt, DEAD + 1);
    chk(gateLo[0] == 1, "R4 lone low request", gateLo[0], 1);

    loReq = 3'b011; step(40);
    chk(gateLo == 3'b011 && gateHi == 0, "R4 low on U and V", {gateHi, gateLo}, 3);
    hiReq = 3'b100; loReq = 3'b111; step(40);
    chk(!gateHi[2] && !gateLo[2], "R3 interlock W", {gateHi[2], gateLo[2]}, 0);
    loReq = 3'b011; step(40);
    chk(gateHi == 3'b100, "R4 high on W", gateHi, 4);

    // R10 high-side lockout with hysteresis
    vbsMv[47:32] = 16'd9900; step(5);
    chk(gateHi[2] == 0, "R10 lockout W high", gateHi[2], 0);
    chk(gateLo == 3'b011, "R10 other gates untouched", gateLo, 3);
    vbsMv[47:32] = 16'd11000; step(40);
    chk(gateHi[2] == 0, "R10 band keeps lockout", gateHi[2], 0);
    vbsMv[47:32] = 16'd11500; step(40);
    chk(gateHi[2] == 1, "R10 release", gateHi[2], 1);

    // R9 control-supply lockout with hysteresis
    vccMv = 16'd11000; step(40);
    chk(gateHi == 3'b100 && gateLo == 3'b011, "R9 band keeps running", {gateHi, gateLo}, 6'o43);
    vccMv = 16'd10400; step(5);
    chk(gateHi == 0 && gateLo == 0, "R9 lockout engaged", {gateHi, gateLo}, 0);
    vccMv = 16'd11000; step(40);
    chk(gateHi == 0 && gateLo == 0, "R9 band keeps lockout", {gateHi, gateLo}, 0);
    vccMv = 16'd12000; step(40);
    chk(gateHi == 3'b100 && gateLo == 3'b011, "R9 release", {gateHi, gateLo}, 6'o43);

    // R2 shutdown
    sdExt = 0; step(3);
    chk(gateHi == 0 && gateLo == 0, "R2 shutdown all off", {gateHi, gateLo}, 0);
    sdExt = 1; step(40);

    // R6/R7 trip with line looped back
    tripIn = 1; step(3);
    chk(gateLo[0] == 0 && gateHi[0] == 0, "R6 U cut", gateLo[0], 0);
    chk(faultOe == 1, "R6 fault drive", faultOe, 1);
    chk(gateLo[1] == 1, "R7 V not cut directly", gateLo[1], 1);
    step(3);
    chk(gateLo[1] == 0 && gateHi[2] == 0, "R7 V/W cut via line", {gateLo[1], gateHi[2]}, 0);

    // R8 hold after trip clears
    tripIn = 0; cnt = 0;
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (faultOe) cnt++; else break;
    end
    chk(cnt == HOLD + 2, "R8 hold length", cnt, HOLD + 2);
    step(40);
    chk(gateHi == 3'b100 && gateLo == 3'b011, "R8 recovery", {gateHi, gateLo}, 6'o43);

    // R7 without loop-back: trip has no effect on V and W
    fbEn = 0; tripIn = 1; step(10);
    chk(gateLo[1] == 1 && gateHi[2] == 1, "R7 V/W ignore trip", {gateLo[1], gateHi[2]}, 3);
    chk(gateLo[0] == 0, "R6 U cut without loop-back", gateLo[0], 0);
    tripIn = 0; step(HOLD + 40); fbEn = 1;

    // Random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      int r, ph;
      r = int'($urandom % 1000);
      ph = int'($urandom % 3);
      if (r < 40) begin
        hiReq[ph] = $urandom % 2;
        loReq[ph] = $urandom % 2;
      end else if (r < 43)  tripIn = ~tripIn;
      else if (r < 46)      sdExt = ~sdExt;
      else if (r < 49)      vccMv = 16'(9500 + $urandom % 3500);
      else if (r < 55)      vbsMv[ph*16 +: 16] = 16'(9000 + $urandom % 3500);
      else if (r < 57)      fbEn = ~fbEn;
      step(1);
    end
    tripIn = 0; sdExt = 1;
    step(5);
    summary();
  end
endmodule